// File: doc/BRIEF.md
# SMBus Address Resolution Target Responder

This block is the byte-level decision logic for an SMBus target that takes part in address resolution for several device identifiers at once. A byte engine upstream handles the wire timing. It passes in every received byte together with start and stop markers, and it asks for reply bytes during read phases. For each written byte the block answers ACK or NACK on the same cycle. For each requested read byte it supplies the value. Internally it holds three things for each of its `N_ID` stored 128-bit identifiers: an assigned 7-bit address, an address-valid flag and an address-resolved flag.

An address-resolution master steers the flags. It enumerates the identifiers with the general identifier query, hands each one a slave address with the assign command, and can later clear the resolved flags in bulk or per address. It can also query one identifier directly through its assigned address. Each of these transactions ends in a CRC-8 packet error code, and a write that carries a bad code leaves the state untouched.

Top module: `smbus_arp_target`

## Requirements
- R1: Only the device default address is ACKed as the first byte after a start: 0xC2 opens a command, and 0xC3 is accepted only after a repeated start that follows an identifier query command byte. Any other first byte is NACKed, and so is every byte after it up to the next start. A byte received before any start is NACKed.
- R2: The packet error code is CRC-8 with polynomial 0x07 and initial value 0x00, shifted MSB first over every byte of the transaction, including both address bytes and the reply bytes. A written error byte that differs from the running CRC is NACKed and has no effect on the flags or addresses.
- R3: Command 0x01 (prepare) or 0x02 (general reset), followed by a correct error byte, clears the resolved flag of every identifier.
- R4: After command 0x03 (general query) and a read-address repeated start, the reply is built from the lowest-index identifier whose resolved flag is clear. It is sent in this order:
  - count byte 0x11;
  - the 16 identifier bytes, most significant byte first;
  - an address byte, which is {address,1} when the valid flag is set and 0xFF otherwise;
  - the error code.
  Any read after that returns 0xFF.
- R5: Command 0x03 is NACKed when every identifier has its resolved flag set.
- R6: Command 0x04 (assign) expects a count byte of 0x11, which is NACKed otherwise. It then compares the 16 incoming identifier bytes against every stored identifier as they arrive. The first byte after which no stored identifier still matches is NACKed, and so is every later byte of the transaction.
- R7: A complete assign with a correct error byte stores bits [7:1] of its address byte into the lowest-index fully matched identifier and sets both its valid and resolved flags. A valid flag never clears once set, and a resolved flag is only ever set together with a valid flag.
- R8: Any other command byte is a directed command. Bits [7:1] are compared with the address of each identifier whose valid flag is set. When bit 0 is 1, the command is a directed query and is answered with that identifier in the R4 format. When bit 0 is 0, the command is a directed reset: with a correct error byte it clears the resolved flag of that identifier only.
- R9: A directed command whose bits [7:1] match no valid identifier is NACKed.
- R10: After reset all valid and resolved flags are clear.
- R11: Each identifier is enumerated and assigned on its own. Once the lowest one is resolved, the general query answers with the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ids | input | 128*N_ID | Stored identifiers; identifier i occupies bits [128*i+127:128*i], with its first transmitted byte at the top |
| bus_start | input | 1 | One-cycle pulse for a start or repeated start condition |
| bus_stop | input | 1 | One-cycle pulse for a stop condition |
| rx_valid | input | 1 | A written byte is presented on rx_byte |
| rx_byte | input | 8 | Received byte |
| rx_ack | output | 1 | ACK (1) or NACK (0) for the presented byte, valid while rx_valid |
| tx_req | input | 1 | The engine consumes one reply byte this cycle |
| tx_byte | output | 8 | Reply byte offered for the next read |

## Verification
The bench aims at the points where a responder of this kind goes wrong. An assign identifier that diverges at byte 5 must be ACKed up to byte 4 and NACKed from byte 5 on; a design that NACKed only the single mismatching byte, or kept ACKing, would let a partial match through. Two identifiers that differ only in their last byte check that the candidate set narrows correctly, and that the lower index is not picked after it has dropped out. The bench also checks these points:
- a bad error code must leave the next general query unchanged;
- a directed reset must re-expose only the addressed identifier, now with its kept address rather than 0xFF;
- a general query with every identifier resolved must be NACKed at the command byte, not at the address byte.

// File: rtl/smbus_arp_target.sv
module smbus_arp_target #(
  parameter int N_ID = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [128*N_ID-1:0]   ids,
  input  logic                  bus_start,
  input  logic                  bus_stop,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  output logic                  rx_ack,
  input  logic                  tx_req,
  output logic [7:0]            tx_byte
);
  localparam int SW = (N_ID > 1) ? $clog2(N_ID) : 1;
  localparam logic [7:0] ADR_W = 8'hC2;
  localparam logic [7:0] ADR_R = 8'hC3;
  localparam logic [7:0] CNT   = 8'h11;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CMD, S_PEC, S_ACNT, S_AID, S_AADR, S_APEC, S_WAITRD, S_RD
  } st_t;
  typedef enum logic [1:0] {OP_PREP, OP_RSTG, OP_RSTD} op_t;

  st_t            st;
  op_t            op;
  logic           rd_pend;
  logic [SW-1:0]  sel;
  logic [4:0]     idx;
  logic [N_ID-1:0] cand, av, ar;
  logic [7:0]     crc;
  logic [6:0]     new_adr;
  logic [6:0]     sadr [N_ID];

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int b = 0; b < 8; b++) x = x[7] ? ({x[6:0], 1'b0} ^ 8'h07) : {x[6:0], 1'b0};
    return x;
  endfunction

  function automatic logic [7:0] id_byte(input int i, input int k);
    return ids[i*128 + 127 - 8*k -: 8];
  endfunction

  logic [SW-1:0]  free_sel, dir_sel, cand_sel;
  logic           free_any, dir_any, ack_c;
  logic [N_ID-1:0] mm;

  always_comb begin
    free_sel = '0; free_any = 1'b0;
    dir_sel = '0;  dir_any = 1'b0;
    cand_sel = '0;
    for (int i = N_ID-1; i >= 0; i--) begin
      if (!ar[i]) begin free_sel = SW'(i); free_any = 1'b1; end
      if (av[i] && sadr[i] == rx_byte[7:1]) begin dir_sel = SW'(i); dir_any = 1'b1; end
      if (cand[i]) cand_sel = SW'(i);
    end
    for (int i = 0; i < N_ID; i++)
      mm[i] = cand[i] && (id_byte(i, int'(idx[3:0])) == rx_byte);
  end

  always_comb begin
    case (st)
      S_ADDR:         ack_c = rd_pend ? (rx_byte == ADR_R) : (rx_byte == ADR_W);
      S_CMD: case (rx_byte)
               8'h01, 8'h02, 8'h04: ack_c = 1'b1;
               8'h03:               ack_c = free_any;
               default:             ack_c = dir_any;
             endcase
      S_PEC, S_APEC:  ack_c = (rx_byte == crc);
      S_ACNT:         ack_c = (rx_byte == CNT);
      S_AID:          ack_c = |mm;
      S_AADR:         ack_c = 1'b1;
      default:        ack_c = 1'b0;
    endcase
  end
  assign rx_ack = rx_valid & ack_c;

  always_comb begin
    tx_byte = 8'hFF;
    if (st == S_RD) begin
      if (idx == 5'd0)       tx_byte = CNT;
      else if (idx <= 5'd16) tx_byte = id_byte(int'(sel), int'(idx) - 1);
      else if (idx == 5'd17) tx_byte = av[sel] ? {sadr[sel], 1'b1} : 8'hFF;
      else if (idx == 5'd18) tx_byte = crc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_PREP; rd_pend <= 1'b0; sel <= '0; idx <= '0;
      cand <= '0; av <= '0; ar <= '0; crc <= '0; new_adr <= '0;
      for (int i = 0; i < N_ID; i++) sadr[i] <= '0;
    end else if (bus_start) begin
      st <= S_ADDR;
      rd_pend <= (st == S_WAITRD);
      if (st != S_WAITRD) crc <= '0;
    end else if (bus_stop) begin
      st <= S_IDLE;
      rd_pend <= 1'b0;
    end else if (rx_valid) begin
      crc <= crc8(crc, rx_byte);
      if (!ack_c) st <= S_IDLE;
      else case (st)
        S_ADDR: begin
          rd_pend <= 1'b0;
          idx <= '0;
          st <= rd_pend ? S_RD : S_CMD;
        end
        S_CMD: case (rx_byte)
          8'h01: begin op <= OP_PREP; st <= S_PEC; end
          8'h02: begin op <= OP_RSTG; st <= S_PEC; end
          8'h03: begin sel <= free_sel; st <= S_WAITRD; end
          8'h04: st <= S_ACNT;
          default: begin
            sel <= dir_sel;
            if (rx_byte[0]) st <= S_WAITRD;
            else begin op <= OP_RSTD; st <= S_PEC; end
          end
        endcase
        S_PEC: begin
          if (op == OP_RSTD) ar[sel] <= 1'b0;
          else ar <= '0;
          st <= S_IDLE;
        end
        S_ACNT: begin cand <= '1; idx <= '0; st <= S_AID; end
        S_AID: begin
          cand <= mm;
          idx <= idx + 5'd1;
          if (idx == 5'd15) st <= S_AADR;
        end
        S_AADR: begin new_adr <= rx_byte[7:1]; st <= S_APEC; end
        S_APEC: begin
          sadr[cand_sel] <= new_adr;
          av[cand_sel] <= 1'b1;
          ar[cand_sel] <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end else if (tx_req && st == S_RD) begin
      if (idx <= 5'd17) crc <= crc8(crc, tx_byte);
      if (idx != 5'd19) idx <= idx + 5'd1;
    end
  end

  // R6
  nack_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ack && !bus_start && !bus_stop |=> st == S_IDLE);
  // R5
  all_resolved_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && st == S_CMD && rx_byte == 8'h03 && (&ar) |-> !rx_ack);
  // R3
  bulk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ack && st == S_PEC && op != OP_RSTD && !bus_start && !bus_stop |=> ar == '0);
  // R7
  assign_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ack && st == S_APEC && !bus_start && !bus_stop |=> (av & ar) != '0);
  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (av & $past(av)) == $past(av));
  // R7
  resolved_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar & ~av) == '0);
endmodule

// File: tb/tb_smbus_arp_target.sv
`timescale 1ns/1ps
module tb_smbus_arp_target;
  localparam int N_ID = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [128*N_ID-1:0] ids;
  logic bus_start = 0, bus_stop = 0, rx_valid = 0, tx_req = 0;
  logic [7:0] rx_byte = 0;
  logic rx_ack;
  logic [7:0] tx_byte;
  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] bcrc = 0;

  always #2.5 clk = ~clk;

  smbus_arp_target #(.N_ID(N_ID)) dut (
    .clk(clk), .rst_n(rst_n), .ids(ids), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ack(rx_ack), .tx_req(tx_req), .tx_byte(tx_byte));

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int b = 0; b < 8; b++) x = x[7] ? ({x[6:0], 1'b0} ^ 8'h07) : {x[6:0], 1'b0};
    return x;
  endfunction

  function automatic logic [7:0] ub(input int i, input int k);
    if (i == 1 && k == 15) return 8'h99;
    return 8'h10 + 8'(k);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic sta(input bit rep);
    @(negedge clk); bus_start = 1;
    @(posedge clk); #1 bus_start = 0;
    if (!rep) bcrc = 0;
  endtask

  task automatic sto();
    @(negedge clk); bus_stop = 1;
    @(posedge clk); #1 bus_stop = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit eack, input string tag);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    #1 chk(rx_ack == eack, tag, {7'd0, rx_ack}, {7'd0, eack});
    @(posedge clk); #1 rx_valid = 0;
    bcrc = crc8(bcrc, b);
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    @(negedge clk); tx_req = 1;
    #1 chk(tx_byte == e, tag, tx_byte, e);
    @(posedge clk); #1 tx_req = 0;
    bcrc = crc8(bcrc, e);
  endtask

  task automatic reply(input int k, input logic [7:0] ab, input string tag);
    sta(1); send(8'hC3, 1, {tag, " rd-addr"});
    rd(8'h11, {tag, " count"});
    for (int j = 0; j < 16; j++) rd(ub(k, j), {tag, " id"});
    rd(ab, {tag, " addr"});
    rd(bcrc, {tag, " pec"});
    rd(8'hFF, {tag, " past-end"});
    sto();
  endtask

  task automatic query(input int k, input logic [7:0] ab, input string tag);
    sta(0); send(8'hC2, 1, tag); send(8'h03, 1, tag);
    reply(k, ab, tag);
  endtask

  task automatic assign_id(input int k, input logic [6:0] a, input bit goodpec, input string tag);
    sta(0); send(8'hC2, 1, tag); send(8'h04, 1, tag); send(8'h11, 1, tag);
    for (int j = 0; j < 16; j++) send(ub(k, j), 1, tag);
    send({a, 1'b0}, 1, tag);
    if (goodpec) send(bcrc, 1, {tag, " pec"});
    else send(bcrc ^ 8'h5A, 0, {tag, " bad pec"});
    sto();
  endtask

  localparam logic [8:0] ADDR_VEC [6] = '{
    {8'hC2, 1'b1}, {8'hC3, 1'b0}, {8'h00, 1'b0}, {8'hC0, 1'b0}, {8'h61, 1'b0}, {8'hC6, 1'b0}};

  initial begin
    for (int i = 0; i < N_ID; i++)
      for (int j = 0; j < 16; j++) ids[i*128 + 127 - 8*j -: 8] = ub(i, j);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    send(8'hC2, 0, "R10 byte before start");
    for (int v = 0; v < 6; v++) begin
      sta(0);
      send(ADDR_VEC[v][8:1], ADDR_VEC[v][0], "R1 address screen");
      if (!ADDR_VEC[v][0]) send(8'h03, 0, "R1 after bad address");
      sto();
    end

    query(0, 8'hFF, "R4 R10 query fresh");
    assign_id(0, 7'h20, 1, "R7 assign id0");
    query(1, 8'hFF, "R11 query next id");

    sta(0); send(8'hC2, 1, "R6"); send(8'h04, 1, "R6"); send(8'h11, 1, "R6");
    for (int j = 0; j < 5; j++) send(ub(0, j), 1, "R6 prefix match");
    send(8'h77, 0, "R6 mismatch byte");
    send(ub(0, 6), 0, "R6 after mismatch");
    sto();

    sta(0); send(8'hC2, 1, "R6"); send(8'h04, 1, "R6"); send(8'h10, 0, "R6 bad count"); sto();

    assign_id(1, 7'h21, 0, "R2");
    query(1, 8'hFF, "R2 no effect");
    assign_id(1, 7'h21, 1, "R7 assign id1");

    sta(0); send(8'hC2, 1, "R5"); send(8'h03, 0, "R5 all resolved"); sto();

    sta(0); send(8'hC2, 1, "R8"); send(8'h43, 1, "R8 directed query");
    reply(1, 8'h43, "R8 directed id1");

    sta(0); send(8'hC2, 1, "R9"); send(8'h61, 0, "R9 unknown target"); sto();

    sta(0); send(8'hC2, 1, "R8"); send(8'h40, 1, "R8 directed reset");
    send(bcrc, 1, "R8 reset pec"); sto();
    query(0, 8'h41, "R8 only id0 cleared");

    sta(0); send(8'hC2, 1, "R3"); send(8'h01, 1, "R3 prepare");
    send(bcrc, 1, "R3 pec"); sto();
    assign_id(0, 7'h20, 1, "R3 reassign id0");
    query(1, 8'h43, "R3 id1 cleared");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule